// File: doc/BRIEF.md
# Buffered character queue with fill-level trigger

This block is the character store for one direction of a serial port. Characters enter through a push port and leave through a pop port in arrival order. The receive instance is built 11 bits wide, so that each character travels with three bits of line-error status. The transmit instance is 8 bits wide. The depth is 64 entries. A parameter picks the direction. The direction decides how the trigger output is computed: the receive side counts stored characters, and the transmit side counts free slots.

The trigger threshold comes from one of two configuration fields. A 2-bit selector picks one of four fixed levels. A 6-bit programmed value overrides the selector whenever it is nonzero. When the queue is switched off, which is its state after reset, it acts as a single-character holding register and the threshold is 1. The trigger output drives an interrupt request. The ready output gives a simpler "data present" (receive) or "room present" (transmit) indication for a DMA engine.

A new setting of the enable input takes effect one clock after it is applied. That clock also empties the queue. A flush input empties the queue in one clock and does not touch the configuration fields.

Top module: `uart_tfifo`

## Requirements
- R1: With `q_en` high, up to 64 entries of the full parameterized width are stored and popped in arrival order. `pop_data` shows the popped entry from the clock after the pop.
- R2: With `thr_prog` equal to 0, `thr_sel` values 0,1,2,3 select thresholds 8,16,56,60 on the receive side and 8,16,32,56 on the transmit side.
- R3: A nonzero `thr_prog` (1..63) is the threshold and overrides `thr_sel`.
- R4: The receive `trig` is high when `level` is greater than or equal to the threshold. The transmit `trig` is high when the free space (capacity minus `level`) is greater than or equal to the threshold.
- R5: With the enable state low, capacity is 1 entry and the threshold is 1, whatever the two configuration fields hold.
- R6: The receive `ready` is high when `level` is nonzero. The transmit `ready` is high when `level` is below capacity.
- R7: A push into a full queue is dropped and sets the sticky `overrun` flag. A push and a pop in the same clock on a full queue both take effect.
- R8: A pop on an empty queue leaves `level` and `pop_data` unchanged.
- R9: `flush` empties the queue and clears `overrun` in one clock. It leaves the threshold configuration unchanged.
- R10: A change of `q_en` empties the queue. The new capacity and threshold apply from the following clock.
- R11: After reset, `level` is 0, `overrun` is 0, `pop_data` is 0 and the queue is in the disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_en | input | 1 | Queue enable; low selects single-entry holding mode |
| flush | input | 1 | Empty the queue and clear overrun |
| push | input | 1 | Write `push_data` this clock |
| push_data | input | W | Entry to store (character plus status bits on the receive side) |
| pop | input | 1 | Remove the oldest entry this clock |
| pop_data | output | W | Last popped entry |
| thr_sel | input | 2 | Fixed threshold selector |
| thr_prog | input | 6 | Programmed threshold, 0 = use selector |
| level | output | 7 | Number of stored entries |
| trig | output | 1 | Threshold reached (interrupt request) |
| ready | output | 1 | DMA ready: data present (receive) or room present (transmit) |
| overrun | output | 1 | Sticky flag: a push was dropped |

## Verification
The assertions assume that `q_en` changes only on clocks with no push and no pop. That clock is spent emptying the queue, so any push or pop on it would be lost. The bench honours this by following every change of enable with an idle clock. The assertions also assume that `flush` is a single-clock pulse. The bench raises it for exactly one cycle. The configuration fields may change on any cycle, because the trigger follows them combinationally. The sweep exploits this by cycling through all twelve configurations at every fill level from 0 to 64.

// File: rtl/uart_tfifo_pkg.sv
// Package: shared helpers for the triggered character queue.
// Assumes a queue depth of 64 so the fixed levels fit.
package uart_tfifo_pkg;

    // Fixed threshold chosen by the 2-bit selector, per direction.
    function automatic int unsigned sel_level(bit is_rx, logic [1:0] s);
        case (s)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return is_rx ? 56 : 32;
            default: return is_rx ? 60 : 56;
        endcase
    endfunction

endpackage

// File: rtl/uart_tfifo_store.sv
// Module: circular storage with occupancy counter and overrun flag.
// Assumes DEPTH is a power of two and cap never exceeds DEPTH.
// A clear empties the store and wins over push and pop in the same clock.
module uart_tfifo_store #(
    parameter int W     = 11,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             ovr_clr,
    input  logic [CNT_W-1:0] cap,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic [CNT_W-1:0] count,
    output logic             overrun
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_pop;
    logic             do_push;

    // Accepted pop and push after the emptiness, capacity and clear checks.
    always_comb begin
        do_pop  = pop && (count != '0) && !clear;
        do_push = push && !clear && ((count < cap) || do_pop);
    end

    // Entry write; storage needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Registered read port, holding its value when nothing is popped.
    always_ff @(posedge clk) begin
        if (!rst_n)      pop_data <= '0;
        else if (do_pop) pop_data <= mem[rd_ptr];
    end

    // Sticky overrun: set by a dropped push, cleared by flush.
    always_ff @(posedge clk) begin
        if (!rst_n || ovr_clr)              overrun <= 1'b0;
        else if (push && !do_push && !clear) overrun <= 1'b1;
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0 && !clear) |=> ($stable(pop_data) && count == '0));
    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));
    // R7
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(push && count == cap && !pop));
endmodule

// File: rtl/uart_tfifo_thresh.sv
// Module: picks the active trigger threshold.
// A nonzero programmed value wins over the selector; the disabled mode forces 1.
module uart_tfifo_thresh #(
    parameter bit IS_RX  = 1'b1,
    parameter int CNT_W  = 7
) (
    input  logic             en,
    input  logic [1:0]       sel,
    input  logic [CNT_W-2:0] prog,
    output logic [CNT_W-1:0] thr
);
    import uart_tfifo_pkg::*;

    // Threshold priority: disabled, then programmed, then selected.
    always_comb begin
        if (!en)              thr = CNT_W'(1);
        else if (prog != '0)  thr = CNT_W'(prog);
        else                  thr = CNT_W'(sel_level(IS_RX, sel));
    end
endmodule

// File: rtl/uart_tfifo.sv
// Module: triggered character queue for one serial direction.
// Assumes q_en changes only on clocks without push or pop; the mode change
// empties the queue and the new mode applies from the next clock.
module uart_tfifo #(
    parameter bit IS_RX = 1'b1,
    parameter int W     = 11,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_en,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    input  logic [1:0]       thr_sel,
    input  logic [CNT_W-2:0] thr_prog,
    output logic [CNT_W-1:0] level,
    output logic             trig,
    output logic             ready,
    output logic             overrun
);
    logic             en_q;
    logic             mode_chg;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] thr;

    // Registered enable state; the mode in force this clock.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= q_en;
    end

    // Mode-change detection and capacity of the current mode.
    always_comb begin
        mode_chg = (q_en != en_q);
        cap      = en_q ? CNT_W'(DEPTH) : CNT_W'(1);
    end

    uart_tfifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush || mode_chg),
        .ovr_clr   (flush),
        .cap       (cap),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .count     (level),
        .overrun   (overrun)
    );

    uart_tfifo_thresh #(.IS_RX(IS_RX), .CNT_W(CNT_W)) u_thresh (
        .en   (en_q),
        .sel  (thr_sel),
        .prog (thr_prog),
        .thr  (thr)
    );

    generate
        if (IS_RX) begin : g_rx
            // Receive side: trigger on stored count, ready on any data.
            always_comb begin
                trig  = (level >= thr);
                ready = (level != '0);
            end
        end else begin : g_tx
            // Transmit side: trigger on free space, ready on any room.
            always_comb begin
                trig  = ((cap - level) >= thr);
                ready = (level < cap);
            end
        end
    endgenerate

    // R5
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (level <= CNT_W'(1)));
    // R10
    mode_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (level == '0));
endmodule

// File: tb/uart_tfifo_bench.sv
`timescale 1ns/1ps
module uart_tfifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        q_en = 1'b0;
    logic        flush = 1'b0;
    logic        push = 1'b0;
    logic [10:0] push_data = '0;
    logic        pop = 1'b0;
    logic [1:0]  thr_sel = '0;
    logic [5:0]  thr_prog = '0;
    logic [10:0] rx_pop_data;
    logic [7:0]  tx_pop_data;
    logic [6:0]  rx_level, tx_level;
    logic        rx_trig, tx_trig, rx_ready, tx_ready, rx_ovr, tx_ovr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model
    logic [10:0] q[$];
    logic [10:0] exp_pop = '0;
    bit          m_en = 0;
    bit          m_ovr = 0;

    always #10 clk = ~clk;

    uart_tfifo #(.IS_RX(1'b1), .W(11)) u_uart_tfifo (
        .clk(clk), .rst_n(rst_n), .q_en(q_en), .flush(flush), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(rx_pop_data),
        .thr_sel(thr_sel), .thr_prog(thr_prog), .level(rx_level),
        .trig(rx_trig), .ready(rx_ready), .overrun(rx_ovr));

    uart_tfifo #(.IS_RX(1'b0), .W(8)) u_uart_tfifo_tx (
        .clk(clk), .rst_n(rst_n), .q_en(q_en), .flush(flush), .push(push),
        .push_data(push_data[7:0]), .pop(pop), .pop_data(tx_pop_data),
        .thr_sel(thr_sel), .thr_prog(thr_prog), .level(tx_level),
        .trig(tx_trig), .ready(tx_ready), .overrun(tx_ovr));

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cap_m();
        return m_en ? 64 : 1;
    endfunction

    function automatic int thr_m(bit is_rx);
        if (!m_en) return 1;
        if (thr_prog != 0) return int'(thr_prog);
        case (thr_sel)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return is_rx ? 56 : 32;
            default: return is_rx ? 60 : 56;
        endcase
    endfunction

    task automatic check_trig(string req);
        int n = q.size();
        chk(rx_trig == (n >= thr_m(1)), {req, " rx trig"}, rx_trig, n >= thr_m(1));
        chk(tx_trig == ((cap_m() - n) >= thr_m(0)), {req, " tx trig"}, tx_trig,
            (cap_m() - n) >= thr_m(0));
    endtask

    task automatic check_all(string req);
        int n = q.size();
        chk(rx_level == 7'(n), {req, " rx level"}, rx_level, n);
        chk(tx_level == 7'(n), {req, " tx level"}, tx_level, n);
        check_trig(req);
        // R6 ready indications
        chk(rx_ready == (n != 0), {req, " R6 rx ready"}, rx_ready, n != 0);
        chk(tx_ready == (n < cap_m()), {req, " R6 tx ready"}, tx_ready, n < cap_m());
        chk(rx_ovr == m_ovr && tx_ovr == m_ovr, {req, " overrun"}, rx_ovr, m_ovr);
        chk(rx_pop_data == exp_pop, {req, " rx pop_data"}, rx_pop_data, exp_pop);
        chk(tx_pop_data == exp_pop[7:0], {req, " tx pop_data"}, tx_pop_data, exp_pop[7:0]);
    endtask

    // One clock of push/pop with the model advanced alongside.
    task automatic cyc(bit pu, bit po, logic [10:0] d);
        bit dpop, dpush;
        @(negedge clk);
        push = pu; pop = po; push_data = d;
        @(posedge clk);
        #1;
        push = 0; pop = 0;
        dpop  = po && q.size() > 0;
        dpush = pu && (q.size() < cap_m() || dpop);
        if (dpop) exp_pop = q.pop_front();
        if (dpush) q.push_back(d);
        if (pu && !dpush) m_ovr = 1;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1;
        @(posedge clk);
        #1;
        flush = 0;
        q.delete();
        m_ovr = 0;
    endtask

    task automatic set_en(bit e);
        @(negedge clk);
        q_en = e;
        @(posedge clk);
        #1;
        q.delete();
        m_en = e;
        cyc(0, 0, '0);
    endtask

    function automatic logic [10:0] pat(int i);
        return {3'(i % 8), 8'((i * 37 + 5) % 256)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int plist[8] = '{1, 5, 17, 32, 59, 63, 3, 40};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state, disabled mode
        check_all("R11");

        // R5 holding register: capacity 1, threshold 1 despite config
        thr_sel = 2'd3; thr_prog = 6'd40;
        cyc(1, 0, pat(1));
        check_all("R5 one held");
        cyc(1, 0, pat(2));
        check_all("R5 R7 second dropped");
        cyc(0, 1, '0);
        check_all("R5 pop held entry");
        cyc(0, 1, '0);
        check_all("R8 empty pop disabled");
        do_flush();
        check_all("R9 flush clears overrun");

        // R10 enable change empties
        cyc(1, 0, pat(3));
        set_en(1);
        check_all("R10 enable empties");

        // R2 R3 R4 sweep: every fill level x twelve configurations
        for (int lvl = 0; lvl <= 64; lvl++) begin
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                thr_sel = 2'(c % 4);
                thr_prog = (c < 4) ? 6'd0 : 6'(plist[c - 4]);
                #1;
                check_trig(c < 4 ? "R2 R4" : "R3 R4");
            end
            check_all("R1 fill");
            if (lvl < 64) cyc(1, 0, pat(lvl + 10));
        end

        // R7 push into full queue
        cyc(1, 0, pat(200));
        check_all("R7 full push dropped");
        cyc(1, 1, pat(201));
        check_all("R7 full push+pop");

        // R1 drain in order
        for (int i = 0; i < 64; i++) begin
            cyc(0, 1, '0);
            check_all("R1 drain order");
        end
        cyc(0, 1, '0);
        check_all("R8 empty pop");
        cyc(1, 1, pat(300));
        check_all("R8 push+pop on empty");

        // R9 flush keeps configuration
        thr_sel = 2'd1; thr_prog = 6'd0;
        for (int i = 0; i < 20; i++) cyc(1, 0, pat(400 + i));
        check_all("R9 before flush");
        do_flush();
        check_all("R9 after flush");
        for (int i = 0; i < 16; i++) cyc(1, 0, pat(500 + i));
        check_all("R9 config kept");

        // R10 disable empties and restores capacity 1
        set_en(0);
        check_all("R10 disable empties");
        cyc(1, 0, pat(600));
        check_all("R10 R5 held after disable");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule